// File: doc/BRIEF.md
# Four-Lane Single-Precision Add/Subtract Unit

This unit takes two 128-bit operands, each holding four IEEE-754 single-precision values, and returns a 128-bit result two clock cycles later. A 2-bit mode input picks how the lanes are paired. In packed mode each lane of the first operand is combined with the same lane of the second. In scalar mode only lane 0 is computed and the other lanes are copied from the first operand. In horizontal mode neighbouring lanes inside each operand are combined, and the four results are packed into one vector. A separate subtract input chooses between add and subtract in every mode.

The datapath holds four adders. They round to nearest-even. Subnormal inputs and results are flushed to zero, and every NaN outcome is the single canonical quiet NaN. A new operation may be issued on every cycle. The valid bit travels through the two-stage pipeline beside the data, and a synchronous reset clears it.

Top module: `fp32x4_addsub`

## Requirements
- R1: `out_valid` is high exactly two rising edges after a cycle in which `in_valid` was sampled high, and low two edges after `in_valid` was low. While `rst` is high, and for two edges after it falls, `out_valid` is low.
- R2: `in_mode` 2'b00 (and 2'b11, which behaves the same) is packed mode: result lane i (bits 32i+31:32i) = a lane i op b lane i, for i = 0..3, independently.
- R3: When `in_sub` = 1 the operation is subtraction, with the first-named operand as minuend: packed lane i = a[i] − b[i]. When `in_sub` = 0 it is addition.
- R4: `in_mode` 2'b01 is scalar mode: result lane 0 = a[0] op b[0], and result lanes 1..3 equal a lanes 1..3 bit for bit.
- R5: `in_mode` 2'b10 with add gives the horizontal sum: result lanes 0..3 = a0+a1, a2+a3, b0+b1, b2+b3.
- R6: `in_mode` 2'b10 with subtract takes the lower-indexed lane of each pair as minuend: result lanes 0..3 = a0−a1, a2−a3, b0−b1, b2−b3.
- R7: Finite results are rounded to nearest with ties to even. For example, 0x3F800000 + 0x33800000 gives 0x3F800000.
- R8: An input whose exponent field is 0 counts as zero of its sign. A result whose rounded magnitude is below 2^-126 becomes zero carrying the result's sign.
- R9: A NaN on either input, or infinities of opposite effective sign, gives 0x7FC00000.
- R10: A rounded result whose exponent overflows becomes infinity with the result's sign. An infinity combined with a finite value passes through with its effective sign.
- R11: An exactly zero result is +0 (0x00000000), except when both effective operands are −0, which gives −0 (0x80000000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the valid pipeline |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| in_mode | input | 2 | 00/11 packed, 01 scalar, 10 horizontal |
| in_sub | input | 1 | 1 = subtract, 0 = add |
| in_a | input | 128 | First operand, lane i at bits 32i+31:32i |
| in_b | input | 128 | Second operand, same lane layout |
| out_valid | output | 1 | Result present on `out_res` |
| out_res | output | 128 | Result vector |

## Verification
Two things can happen in the same cycle. One operation's result can leave the output stage while the next operation, in another mode, enters the routing stage. That can carry scalar pass-through lanes, or a horizontal pairing, into the wrong cycle's data. The bench provokes this by issuing operations back to back with mode and subtract chosen at random for each cycle, mixed with idle gaps. A queue-free shift-register model in the bench predicts `out_valid` and all four lanes for every cycle, and the design is compared against it on every clock. A second overlap sits inside one adder: a special value (NaN, infinity, a flushed subnormal) can meet rounding or cancellation on the other input. Directed vectors pair those cases on purpose, and their expected values come from an independent double-precision reference.

// File: rtl/fp32x4_addsub.sv
module fp32x4_addsub #(
  parameter int LANES = 4,
  parameter int W     = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [1:0]          in_mode,
  input  logic                in_sub,
  input  logic [LANES*W-1:0]  in_a,
  input  logic [LANES*W-1:0]  in_b,
  output logic                out_valid,
  output logic [LANES*W-1:0]  out_res
);

  localparam logic [31:0] QNAN = 32'h7FC0_0000;
  localparam int HALF = LANES / 2;

  function automatic logic [31:0] fp_add(input logic [31:0] a, input logic [31:0] b, input logic sub);
    logic sa, sb, sx, sy;
    logic [7:0] ea, eb, ex, ey;
    logic [22:0] ma, mb;
    logic [26:0] mx, my, sh, n;
    logic [27:0] s;
    logic [8:0] d;
    logic signed [10:0] e;
    logic [24:0] r;
    logic up, found;
    int lz;
    sa = a[31]; sb = b[31] ^ sub;
    ea = a[30:23]; eb = b[30:23];
    ma = a[22:0];  mb = b[22:0];
    if ((ea == 8'hFF && ma != 0) || (eb == 8'hFF && mb != 0) ||
        (ea == 8'hFF && eb == 8'hFF && sa != sb)) return QNAN;
    if (ea == 8'hFF) return {sa, 8'hFF, 23'd0};
    if (eb == 8'hFF) return {sb, 8'hFF, 23'd0};
    if (ea == 0 && eb == 0) return {sa & sb, 31'd0};
    if (ea == 0) return {sb, b[30:0]};
    if (eb == 0) return {sa, a[30:0]};
    if (a[30:0] >= b[30:0]) begin
      sx = sa; ex = ea; mx = {1'b1, ma, 3'b000};
      sy = sb; ey = eb; my = {1'b1, mb, 3'b000};
    end else begin
      sx = sb; ex = eb; mx = {1'b1, mb, 3'b000};
      sy = sa; ey = ea; my = {1'b1, ma, 3'b000};
    end
    d = {1'b0, ex} - {1'b0, ey};
    if (d >= 9'd27) sh = 27'd1;
    else sh = (my >> d) | {26'd0, |(my & ((27'd1 << d) - 27'd1))};
    e = signed'({3'b000, ex});
    if (sx == sy) begin
      s = {1'b0, mx} + {1'b0, sh};
      if (s[27]) begin
        n = s[27:1] | {26'd0, s[0]};
        e = e + 11'sd1;
      end else n = s[26:0];
    end else begin
      n = mx - sh;
      if (n == 0) return 32'd0;
      lz = 0; found = 1'b0;
      for (int i = 26; i >= 0; i--) begin
        if (!found) begin
          if (n[i]) found = 1'b1;
          else lz++;
        end
      end
      n = n << lz;
      e = e - 11'(lz);
    end
    up = n[2] & (n[1] | n[0] | n[3]);
    r = {1'b0, n[26:3]} + {24'd0, up};
    if (r[24]) begin
      r = r >> 1;
      e = e + 11'sd1;
    end
    if (e >= 11'sd255) return {sx, 8'hFF, 23'd0};
    if (e <= 11'sd0) return {sx, 31'd0};
    return {sx, e[7:0], r[22:0]};
  endfunction

  logic [W-1:0] xr [LANES];
  logic [W-1:0] yr [LANES];
  logic [W-1:0] x1 [LANES];
  logic [W-1:0] y1 [LANES];
  logic [LANES*W-1:0] lane_res;
  logic v1, sub1, pass1;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (in_mode == 2'b10) begin
        if (i < HALF) begin
          xr[i] = in_a[(2*i)*W +: W];
          yr[i] = in_a[(2*i+1)*W +: W];
        end else begin
          xr[i] = in_b[(2*(i-HALF))*W +: W];
          yr[i] = in_b[(2*(i-HALF)+1)*W +: W];
        end
      end else begin
        xr[i] = in_a[i*W +: W];
        yr[i] = in_b[i*W +: W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_valid;
    sub1  <= in_sub;
    pass1 <= (in_mode == 2'b01);
    for (int i = 0; i < LANES; i++) begin
      x1[i] <= xr[i];
      y1[i] <= yr[i];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_first
      assign lane_res[g*W +: W] = fp_add(x1[g], y1[g], sub1);
    end else begin : g_rest
      assign lane_res[g*W +: W] = pass1 ? x1[g] : fp_add(x1[g], y1[g], sub1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= v1;
    out_res <= lane_res;
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  assert_bubble_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);
  assert_scalar_keep_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 2'b01) |-> ##2 (out_res[LANES*W-1:W] == $past(in_a[LANES*W-1:W], 2)));
  assert_nan_lane0_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode != 2'b10 && in_a[30:23] == 8'hFF && in_a[22:0] != 23'd0)
    |-> ##2 (out_res[31:0] == QNAN));
  assert_cancel_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sub && in_mode != 2'b10 && in_a[31:0] == in_b[31:0] && in_a[30:23] != 8'hFF)
    |-> ##2 (out_res[31:0] == 32'h0000_0000));

endmodule

// File: tb/fp32x4_addsub_tb_top.sv
module fp32x4_addsub_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM = 4000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_mode = 2'b00;
  logic in_sub = 1'b0;
  logic [127:0] in_a = '0, in_b = '0;
  logic out_valid;
  logic [127:0] out_res;
  string cur_tag = "R2";

  int checks = 0, fails = 0;
  bit chk_en = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp32x4_addsub dut_i (.clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_sub(in_sub), .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_res(out_res));

  function automatic real to_real(input logic [31:0] f);
    logic [10:0] ed;
    if (f[30:23] == 8'h00) return $bitstoreal({f[31], 63'd0});
    if (f[30:23] == 8'hFF) return $bitstoreal({f[31], 11'h7FF, 52'd0});
    ed = 11'(int'(f[30:23]) - 127 + 1023);
    return $bitstoreal({f[31], ed, f[22:0], 29'd0});
  endfunction

  function automatic logic [31:0] to_f32(input real r);
    logic [63:0] b;
    int e;
    logic [52:0] m;
    logic [24:0] k;
    logic [28:0] rem;
    bit up;
    b = $realtobits(r);
    if (b[62:52] == 11'h7FF) return (b[51:0] != 0) ? 32'h7FC0_0000 : {b[63], 8'hFF, 23'd0};
    if (b[62:0] == 0) return {b[63], 31'd0};
    e = int'(b[62:52]) - 1023 + 127;
    m = {1'b1, b[51:0]};
    rem = m[28:0];
    up = (rem > 29'h1000_0000) || (rem == 29'h1000_0000 && m[29]);
    k = {1'b0, m[52:29]} + 25'(up);
    if (k[24]) begin e = e + 1; k = 25'h080_0000; end
    if (e >= 255) return {b[63], 8'hFF, 23'd0};
    if (e <= 0) return {b[63], 31'd0};
    return {b[63], 8'(e), k[22:0]};
  endfunction

  function automatic logic [31:0] ref_op(input logic [31:0] a, input logic [31:0] b, input bit sub);
    if ((a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0)) return 32'h7FC0_0000;
    return sub ? to_f32(to_real(a) - to_real(b)) : to_f32(to_real(a) + to_real(b));
  endfunction

  function automatic logic [127:0] model(input logic [1:0] mode, input bit sub,
                                         input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r;
    case (mode)
      2'b01: begin r = a; r[31:0] = ref_op(a[31:0], b[31:0], sub); end
      2'b10: begin
        r[31:0]   = ref_op(a[31:0],  a[63:32],  sub);
        r[63:32]  = ref_op(a[95:64], a[127:96], sub);
        r[95:64]  = ref_op(b[31:0],  b[63:32],  sub);
        r[127:96] = ref_op(b[95:64], b[127:96], sub);
      end
      default: for (int i = 0; i < 4; i++) r[i*32 +: 32] = ref_op(a[i*32 +: 32], b[i*32 +: 32], sub);
    endcase
    return r;
  endfunction

  logic ev1, ev2;
  logic [127:0] ed1, ed2;
  string et1, et2;
  always @(posedge clk) begin
    if (rst) begin
      ev1 <= 1'b0; ev2 <= 1'b0;
    end else begin
      ev1 <= in_valid; ev2 <= ev1;
    end
    ed1 <= model(in_mode, in_sub, in_a, in_b); ed2 <= ed1;
    et1 <= cur_tag; et2 <= et1;
  end

  always @(negedge clk) begin
    if (chk_en) begin
      checks++;
      if (out_valid !== ev2) begin
        fails++;
        $display("FAIL R1 out_valid actual=%b expected=%b at %0t", out_valid, ev2, $time);
      end else if (ev2) begin
        checks++;
        if (out_res !== ed2) begin
          fails++;
          $display("FAIL %s out_res actual=%h expected=%h", et2, out_res, ed2);
        end
      end
    end
  end

  task automatic issue(input logic [1:0] mode, input bit sub, input logic [127:0] a,
                       input logic [127:0] b, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_mode = mode; in_sub = sub; in_a = a; in_b = b; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; cur_tag = "R1";
    end
  endtask

  function automatic logic [31:0] rnd_f();
    int c = $urandom_range(0, 19);
    logic [31:0] v = $urandom;
    case (c)
      0: return {v[31], 31'd0};
      1: return {v[31], 8'hFF, 23'd0};
      2: return {1'b0, 8'hFF, v[22:1], 1'b1};
      3: return {v[31], 8'h00, v[22:0]};
      4: return {v[31], 8'(254 - $urandom_range(0, 2)), v[22:0]};
      5: return {v[31], 8'($urandom_range(1, 3)), v[22:0]};
      6, 7, 8, 9: return {v[31], 8'($urandom_range(120, 132)), v[22:0]};
      default: return {v[31], 8'($urandom_range(1, 254)), v[22:0]};
    endcase
  endfunction

  function automatic logic [127:0] rnd_v();
    logic [127:0] r;
    for (int i = 0; i < 4; i++) r[i*32 +: 32] = rnd_f();
    return r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [127:0] a, b;
    @(posedge clk); chk_en = 1'b1;
    idle(3);
    rst = 1'b0;
    // R2: packed add 1,2,3,4 + 2,0.5,-3,8
    issue(2'b00, 0, {32'h40800000, 32'h40400000, 32'h40000000, 32'h3F800000},
                    {32'h41000000, 32'hC0400000, 32'h3F000000, 32'h40000000}, "R2");
    // R3: order of subtraction, 5-3 and 3-5
    issue(2'b00, 1, {32'h40400000, 32'h40A00000, 32'h40400000, 32'h40A00000},
                    {32'h40A00000, 32'h40400000, 32'h40A00000, 32'h40400000}, "R3");
    // R4: scalar keeps upper lanes of a
    issue(2'b01, 0, {32'h12345678, 32'hDEADBEEF, 32'h7FC00001, 32'h3F800000},
                    {32'h40000000, 32'h40000000, 32'h40000000, 32'h3F800000}, "R4");
    // R5 / R6: horizontal routing
    a = {32'h41000000, 32'h40800000, 32'h40000000, 32'h3F800000};
    b = {32'h42000000, 32'h41800000, 32'h40400000, 32'h40E00000};
    issue(2'b10, 0, a, b, "R5");
    issue(2'b10, 1, a, b, "R6");
    issue(2'b11, 1, a, b, "R2");
    // R7: ties and near ties
    issue(2'b00, 0, {32'h3F800001, 32'h3F800001, 32'h3F800000, 32'h3F800000},
                    {32'h33000000, 32'h33800000, 32'h33C00000, 32'h33800000}, "R7");
    // R8: subnormal inputs and flushed result
    issue(2'b00, 1, {32'h80000005, 32'h00000001, 32'h00800001, 32'h00800001},
                    {32'h3F800000, 32'h80000003, 32'h00000007, 32'h00800000}, "R8");
    // R9: NaN and inf-inf
    issue(2'b00, 0, {32'h3F800000, 32'hFF800000, 32'h7F800000, 32'h7FA00000},
                    {32'hFFC00123, 32'h7F800000, 32'h7F800000, 32'h3F800000}, "R9");
    issue(2'b00, 1, {32'h0, 32'h0, 32'h7F800000, 32'h7F800000}, {32'h0, 32'h0, 32'hFF800000, 32'h7F800000}, "R9");
    // R10: overflow and infinity passthrough
    issue(2'b00, 1, {32'h3F800000, 32'h40000000, 32'hFF7FFFFF, 32'h7F7FFFFF},
                    {32'h7F800000, 32'hFF800000, 32'h7F7FFFFF, 32'h7F7FFFFF}, "R10");
    // R11: signed zeros and exact cancellation
    issue(2'b00, 0, {32'h3FC00000, 32'h80000000, 32'h00000000, 32'h80000000},
                    {32'hBFC00000, 32'h00000000, 32'h80000000, 32'h80000000}, "R11");
    issue(2'b00, 1, {32'hC0A00000, 32'h80000000, 32'h00000000, 32'h80000000},
                    {32'hC0A00000, 32'h00000000, 32'h80000000, 32'h80000000}, "R11");
    idle(2);
    // R1: reset in the middle of traffic clears pending results
    issue(2'b00, 0, rnd_v(), rnd_v(), "R1");
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    idle(2);
    rst = 1'b0;
    idle(2);
    // random streaming, mixed modes back to back
    for (int n = 0; n < N_RANDOM; n++) begin
      logic [1:0] m = 2'($urandom_range(0, 3));
      string t = (m == 2'b01) ? "R4" : (m == 2'b10) ? "R5" : "R2";
      a = rnd_v();
      b = ($urandom_range(0, 4) == 0) ? (a ^ 128'($urandom_range(0, 7))) : rnd_v();
      issue(m, 1'($urandom), a, b, t);
      if ($urandom_range(0, 5) == 0) idle(1);
    end
    idle(4);
    finish_run();
  end
endmodule